// File: doc/BRIEF.md
# Parallel Port Forward-Channel Byte Receiver

This block is the peripheral end of a host-to-peripheral byte channel on a parallel port. The host presents a byte on eight data lines, raises a marker line to say the coming cycle carries data, and pulls an active-low strobe down to say the lines are valid. The block answers on its own acknowledge line once it can take the byte. It takes the byte when the strobe goes back high, then drops the acknowledge so the host can move on. A burst of hundreds of bytes is a run of such handshakes, one per byte.

The bytes go into a small internal FIFO. A valid/ready stream drains that FIFO, for example into an audio serializer or a memory-transfer engine. The acknowledge is raised only when the FIFO has a free slot. A slow consumer therefore holds the host in its strobe-low phase, and no byte is lost. A strobe cycle with the marker low is a control cycle. It is acknowledged but not stored, and a wrapping counter records how many were seen.

The marker, the strobe and the data lines are asynchronous to the system clock. All of them pass together through one synchroniser chain. The byte is held in a register that follows the synchronised lines while the synchronised strobe is low, and it is written to the FIFO on the synchronised rising edge of the strobe.

Top module: `pp_fwd_rx`

## Requirements
- R1: While rst_n is low at a clock edge, pace_ack, s_valid and ctl_count are all zero after that edge.
- R2: For a data cycle (cyc_mark high while strobe_n is low), pace_ack rises while strobe_n is still low. The byte is not offered on s_data/s_valid before strobe_n returns high, and afterwards it is offered with the value bus_in held during the low phase.
- R3: Once raised, pace_ack stays high for as long as strobe_n stays low, and it falls after strobe_n returns high.
- R4: Bytes leave on the stream in the order the host sent them, and every value from 0 to 255 passes through unchanged.
- R5: While the FIFO holds DEPTH bytes, pace_ack is not raised for a new data cycle. It is raised once the consumer has taken a byte.
- R6: While s_valid is high and s_ready is low, s_valid stays high and s_data does not change.
- R7: A control cycle (cyc_mark low while strobe_n is low) is acknowledged, is never written to the FIFO, and adds exactly one to ctl_count, which wraps at its width.
- R8: A control cycle is acknowledged even when the FIFO is full.
- R9: A change on bus_in after strobe_n has returned high does not alter the byte captured for that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_in | input | DW | Host data lines, asynchronous |
| cyc_mark | input | 1 | High marks a data cycle, low marks a control cycle; asynchronous |
| strobe_n | input | 1 | Active-low data-valid strobe from the host; asynchronous |
| pace_ack | output | 1 | Peripheral acknowledge to the host |
| s_data | output | DW | Stream byte |
| s_valid | output | 1 | Stream byte present |
| s_ready | input | 1 | Consumer accepts the byte this cycle |
| ctl_count | output | CMD_W | Wrapping count of control cycles |

## Verification
The bench builds the block with a four-entry FIFO and a four-bit control counter. With that configuration the full FIFO and the stalled host are reached after only four bytes, and the stall can be held and then released by one consumer step. Every byte value from 0 to 255 is sent while the consumer's ready follows a pseudo-random pattern, so stalls and drains interleave across the whole value range. The data lines are scrambled right after each strobe rise. Control cycles are mixed in with both an empty and a full FIFO.

// File: rtl/pp_fwd_pkg.sv
package pp_fwd_pkg;

   // handshake phase seen from the peripheral side
   typedef enum logic {
      HS_IDLE = 1'b0,   // waiting for the strobe to drop, or for space
      HS_ACK  = 1'b1    // acknowledge raised, waiting for the strobe to rise
   } hs_state_t;

   // pointer width for a storage of d entries (at least one bit)
   function automatic int unsigned ptr_w(int unsigned d);
      return (d > 1) ? $clog2(d) : 1;
   endfunction

endpackage

// File: rtl/pp_sync.sv
module pp_sync #(
   parameter int            W       = 1,
   parameter int            STAGES  = 2,
   parameter logic [W-1:0]  RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("pp_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][W-1:0] chain;

   always_ff @(posedge clk) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/pp_byte_fifo.sv
module pp_byte_fifo
   import pp_fwd_pkg::*;
#(
   parameter  int DW    = 8,
   parameter  int DEPTH = 16,
   localparam int AW    = ptr_w(DEPTH),
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [DW-1:0] push_data,
   output logic          full,
   output logic [CW-1:0] count,
   output logic          rd_valid,
   output logic [DW-1:0] rd_data,
   input  logic          rd_ready
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("pp_byte_fifo: DEPTH must be at least 2");
   end

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic          wr_en, rd_en;

   assign wr_en = push && !full;
   assign rd_en = rd_valid && rd_ready;

   // power-of-two depth wraps by itself; other depths compare against the end
   if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
   end else begin : g_wrap
      localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
      assign wr_nxt = (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (wr_en) wr_ptr <= wr_nxt;
         if (rd_en) rd_ptr <= rd_nxt;
         case ({wr_en, rd_en})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   assign full     = (count == CW'(DEPTH));
   assign rd_valid = (count != '0);
   assign rd_data  = mem[rd_ptr];

endmodule

// File: rtl/pp_fwd_fsm.sv
module pp_fwd_fsm
   import pp_fwd_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          strb_s,     // synchronised strobe, active low
   input  logic          mark_s,     // synchronised data/control marker
   input  logic [DW-1:0] bus_s,      // data lines, same delay as strb_s
   input  logic          fifo_full,
   output logic          pace_ack,
   output logic          push,
   output logic [DW-1:0] push_data,
   output logic          ctl_hit
);

   hs_state_t     state;
   logic          is_ctl;
   logic [DW-1:0] hold;
   logic          rise_in_ack;

   assign rise_in_ack = (state == HS_ACK) && strb_s;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= HS_IDLE;
         pace_ack <= 1'b0;
         is_ctl   <= 1'b0;
         hold     <= '0;
      end else begin
         if (!strb_s) hold <= bus_s;
         case (state)
            HS_IDLE: begin
               // a data cycle waits here while there is no free slot
               if (!strb_s && (!mark_s || !fifo_full)) begin
                  state    <= HS_ACK;
                  pace_ack <= 1'b1;
                  is_ctl   <= !mark_s;
               end
            end
            HS_ACK: begin
               if (strb_s) begin
                  state    <= HS_IDLE;
                  pace_ack <= 1'b0;
               end
            end
            default: state <= HS_IDLE;
         endcase
      end
   end

   assign push      = rise_in_ack && !is_ctl;
   assign ctl_hit   = rise_in_ack &&  is_ctl;
   assign push_data = hold;

endmodule

// File: rtl/pp_fwd_rx.sv
module pp_fwd_rx
   import pp_fwd_pkg::*;
#(
   parameter int DW          = 8,
   parameter int DEPTH       = 16,
   parameter int SYNC_STAGES = 2,
   parameter int CMD_W       = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DW-1:0]    bus_in,
   input  logic             cyc_mark,
   input  logic             strobe_n,
   output logic             pace_ack,
   output logic [DW-1:0]    s_data,
   output logic             s_valid,
   input  logic             s_ready,
   output logic [CMD_W-1:0] ctl_count
);

   localparam int SW  = DW + 2;
   localparam int CNW = $clog2(DEPTH + 1);

   if (CMD_W < 1) begin : g_bad_cmdw
      $error("pp_fwd_rx: CMD_W must be at least 1");
   end

   logic [SW-1:0]  sync_q;
   logic           strb_s, mark_s;
   logic [DW-1:0]  bus_s;
   logic           push, ctl_hit, fifo_full;
   logic [DW-1:0]  push_data;
   logic [CNW-1:0] fifo_cnt;

   // strobes idle high; data lines share the chain so they stay aligned
   pp_sync #(
      .W       (SW),
      .STAGES  (SYNC_STAGES),
      .RST_VAL ({2'b11, {DW{1'b0}}})
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({strobe_n, cyc_mark, bus_in}),
      .q     (sync_q)
   );

   assign strb_s = sync_q[SW-1];
   assign mark_s = sync_q[SW-2];
   assign bus_s  = sync_q[DW-1:0];

   pp_fwd_fsm #(.DW(DW)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .strb_s    (strb_s),
      .mark_s    (mark_s),
      .bus_s     (bus_s),
      .fifo_full (fifo_full),
      .pace_ack  (pace_ack),
      .push      (push),
      .push_data (push_data),
      .ctl_hit   (ctl_hit)
   );

   pp_byte_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push),
      .push_data (push_data),
      .full      (fifo_full),
      .count     (fifo_cnt),
      .rd_valid  (s_valid),
      .rd_data   (s_data),
      .rd_ready  (s_ready)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)       ctl_count <= '0;
      else if (ctl_hit) ctl_count <= ctl_count + 1'b1;
   end

endmodule

// File: rtl/pp_fwd_rx_chk.sv
module pp_fwd_rx_chk #(
   parameter int DW    = 8,
   parameter int DEPTH = 16,
   parameter int CNW   = 5,
   parameter int CMD_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pace_ack,
   input logic             strb_s,
   input logic             s_valid,
   input logic             s_ready,
   input logic [DW-1:0]    s_data,
   input logic             push,
   input logic             ctl_hit,
   input logic [CNW-1:0]   fifo_cnt,
   input logic [CMD_W-1:0] ctl_count
);

   a_r1_reset_idle: assert property (@(posedge clk)
      !rst_n |=> (!pace_ack && !s_valid && ctl_count == '0));

   a_r3_ack_held_low: assert property (@(posedge clk) disable iff (!rst_n)
      (pace_ack && !strb_s) |=> pace_ack);

   a_r3_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (pace_ack && strb_s) |=> !pace_ack);

   a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (fifo_cnt < CNW'(DEPTH)));

   a_r6_stream_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (s_valid && !s_ready) |=> (s_valid && $stable(s_data)));

   a_r7_ctl_not_stored: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_hit |=> (fifo_cnt <= $past(fifo_cnt)));

   a_r7_ctl_step: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ctl_count) |-> (ctl_count == $past(ctl_count) + 1'b1));

endmodule

bind pp_fwd_rx pp_fwd_rx_chk #(
   .DW    (DW),
   .DEPTH (DEPTH),
   .CNW   (CNW),
   .CMD_W (CMD_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pace_ack  (pace_ack),
   .strb_s    (strb_s),
   .s_valid   (s_valid),
   .s_ready   (s_ready),
   .s_data    (s_data),
   .push      (push),
   .ctl_hit   (ctl_hit),
   .fifo_cnt  (fifo_cnt),
   .ctl_count (ctl_count)
);

// File: tb/pp_fwd_rx_tb.sv
module pp_fwd_rx_tb;

   localparam int DEPTH = 4;
   localparam int CMD_W = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [7:0]       bus_in = 8'h00;
   logic             cyc_mark = 1'b1;
   logic             strobe_n = 1'b1;
   logic             pace_ack;
   logic [7:0]       s_data;
   logic             s_valid;
   logic             s_ready;
   logic [CMD_W-1:0] ctl_count;

   logic       ready_man = 1'b0;
   logic       rnd_ready = 1'b0;
   logic [7:0] lfsr = 8'hA5;

   int errs = 0;
   int checks = 0;
   logic [7:0] exp_q [0:1023];
   int wr_i = 0;
   int rd_i = 0;

   always #5 clk = ~clk;

   assign s_ready = rnd_ready ? lfsr[0] : ready_man;

   always @(posedge clk) lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};

   pp_fwd_rx #(.DW(8), .DEPTH(DEPTH), .SYNC_STAGES(2), .CMD_W(CMD_W)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_in    (bus_in),
      .cyc_mark  (cyc_mark),
      .strobe_n  (strobe_n),
      .pace_ack  (pace_ack),
      .s_data    (s_data),
      .s_valid   (s_valid),
      .s_ready   (s_ready),
      .ctl_count (ctl_count)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // consumer side: every accepted byte is compared with the expected order (R4)
   always @(negedge clk) begin
      if (rst_n && s_valid && s_ready) begin
         check(s_data == exp_q[rd_i], "R4 stream byte", s_data, exp_q[rd_i]);
         rd_i++;
      end
   end

   // one host handshake; ctl=1 sends a control cycle
   task automatic xfer(input logic [7:0] b, input bit ctl, input int limit, input bit was_empty);
      bus_in   = b;
      cyc_mark = !ctl;
      repeat (2) @(negedge clk);
      strobe_n = 1'b0;
      for (int i = 0; i < limit && !pace_ack; i++) @(negedge clk);
      check(pace_ack == 1'b1, ctl ? "R7 control ack" : "R2 data ack", pace_ack, 1);
      if (!ctl) begin
         exp_q[wr_i] = b;
         wr_i++;
      end
      repeat (3) @(negedge clk);
      check(pace_ack == 1'b1, "R3 ack held while strobe low", pace_ack, 1);
      if (was_empty)
         check(s_valid == 1'b0, "R2 no byte before strobe rise", s_valid, 0);
      strobe_n = 1'b1;
      #1 bus_in = ~b;   // R9: scramble right after the rise
      for (int i = 0; i < 50 && pace_ack; i++) @(negedge clk);
      check(pace_ack == 1'b0, "R3 ack released after rise", pace_ack, 0);
      cyc_mark = 1'b1;
   endtask

   task automatic drain();
      for (int i = 0; i < 2000 && rd_i != wr_i; i++) @(negedge clk);
      check(rd_i == wr_i, "R4 all bytes delivered", rd_i, wr_i);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errs++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check(pace_ack == 1'b0, "R1 ack in reset", pace_ack, 0);
      check(s_valid == 1'b0, "R1 stream empty in reset", s_valid, 0);
      check(ctl_count == '0, "R1 control count in reset", ctl_count, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R2: single byte with a stopped consumer
      xfer(8'h5A, 1'b0, 100, 1'b1);
      repeat (2) @(negedge clk);
      check(s_valid == 1'b1, "R2 byte offered", s_valid, 1);
      check(s_data == 8'h5A, "R2 byte value", s_data, 8'h5A);
      ready_man = 1'b1;
      drain();

      // R4, R9: all values under pseudo-random consumer readiness
      rnd_ready = 1'b1;
      for (int v = 0; v < 256; v++) xfer(v[7:0], 1'b0, 2000, 1'b0);
      rnd_ready = 1'b0;
      ready_man = 1'b1;
      drain();

      // R5, R6: fill, stall the host, then release one slot
      ready_man = 1'b0;
      for (int k = 0; k < DEPTH; k++) xfer(8'hA0 + 8'(k), 1'b0, 100, 1'b0);
      fork
         xfer(8'hC3, 1'b0, 2000, 1'b0);
         begin
            repeat (40) @(negedge clk);
            check(pace_ack == 1'b0, "R5 no ack while full", pace_ack, 0);
            check(s_valid == 1'b1, "R6 valid held", s_valid, 1);
            check(s_data == 8'hA0, "R6 data held", s_data, 8'hA0);
            ready_man = 1'b1;
         end
      join
      drain();

      // R7: control cycles are counted and not stored
      ready_man = 1'b0;
      for (int k = 0; k < 3; k++) xfer(8'h10 + 8'(k), 1'b1, 100, 1'b1);
      repeat (2) @(negedge clk);
      check(s_valid == 1'b0, "R7 nothing stored", s_valid, 0);
      check(ctl_count == 4'd3, "R7 control count", ctl_count, 3);

      // R8: control cycle with a full FIFO
      for (int k = 0; k < DEPTH; k++) xfer(8'h70 + 8'(k), 1'b0, 100, 1'b0);
      xfer(8'hEE, 1'b1, 100, 1'b0);
      repeat (2) @(negedge clk);
      check(ctl_count == 4'd4, "R8 control count while full", ctl_count, 4);
      check(s_data == 8'h70, "R8 head unchanged", s_data, 8'h70);
      ready_man = 1'b1;
      drain();

      // R7: counter wraps at its width
      for (int k = 0; k < 12; k++) xfer(8'h00, 1'b1, 100, 1'b1);
      repeat (2) @(negedge clk);
      check(ctl_count == 4'd0, "R7 control count wraps", ctl_count, 0);

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule